// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block is a first-level interrupt controller. It collects a parameterized set of level-sensitive peripheral interrupt lines, which may number 64, 96, 128 or 160, into one registered interrupt output per CPU. Every CPU owns a complete register bank that holds its own mask. Enabling a line in one bank and leaving it masked in the others sends that peripheral to the chosen CPU only.

Software reaches the banks through a simple word-wide read/write port. Each bank has four groups of N words, where N is the line count divided by 32:

| Group | Word offsets | Contents |
|-------|--------------|----------|
| Raw status | 0 to N-1 | Synchronized input levels |
| Mask view | N to 2N-1 | Current mask |
| Mask-set | 2N to 3N-1 | Write-one-to-mask |
| Mask-clear | 3N to 4N-1 | Write-one-to-unmask |

Masking is atomic because every change is a write-one operation on a single word. The block does no prioritization and has no queue. Software finds pending sources by reading all the status words. There are no polarity or edge controls.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset, every mask bit in every bank is 1, every `cpu_irq` bit is 0 and `rdata` is 0.
- R2: Bit j of status word w (byte offset 4w in a bank) reads as input line 32w+j, taken from `irq_in` through two register stages. The status words are the same in every bank.
- R3: A write to mask-set word w (byte offset 4·(2N+w)) sets to 1 every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to mask-clear word w (byte offset 4·(3N+w)) clears to 0 every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: `cpu_irq[c]` is a register. One clock after the status and bank c's mask satisfy (status AND NOT mask) ≠ 0, it is 1. Otherwise it is 0, so it falls again once the input levels fall.
- R6: Bank c starts at byte address c·S, where S is the smallest power of two that is at least 16·N bytes. A write to bank c changes only bank c's mask and `cpu_irq[c]`.
- R7: Writes to the status words and to the mask-view words (byte offsets 4·(N+w)) have no effect.
- R8: Reads of the mask-view, mask-set and mask-clear words for index w all return mask word w of that bank.
- R9: A read whose in-bank offset is at or above 16·N bytes, or whose bank index is at or above the number of CPUs, returns 0. A write to such an address has no effect.
- R10: A read request returns its data in `rdata` one clock later. `rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Level-sensitive peripheral interrupt lines |
| req | input | 1 | Register access strobe, one access per cycle |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPUS | One interrupt output per CPU bank |

## Verification
The assertions assume that `req`, `we`, `addr` and `wdata` change only between clock edges. They also assume that a write request always carries a defined address and data word. The peripheral lines may toggle at any cycle, because the block treats them as plain levels behind a synchronizer.

The bench changes all its stimulus on the falling edge. It runs a phase of random traffic in which line levels and word writes change together, with addresses that also reach the unused banks and the unused upper part of each window.

// File: rtl/lir_pkg.sv
package lir_pkg;

  // register groups inside one bank, in address order
  typedef enum logic [1:0] {
    GRP_STATUS = 2'd0,
    GRP_MVIEW  = 2'd1,
    GRP_MSET   = 2'd2,
    GRP_MCLR   = 2'd3
  } lir_grp_e;

  // 32-bit words needed to cover the lines
  function automatic int lir_words(int lines);
    return lines / 32;
  endfunction

  // bytes used by one bank: four groups of N words of four bytes
  function automatic int lir_window_bytes(int lines);
    return 16 * lir_words(lines);
  endfunction

  // log2 of the bank stride, which is a power of two covering the window
  function automatic int lir_stride_lg(int lines);
    return $clog2(lir_window_bytes(lines));
  endfunction

  // group that holds a given word offset
  function automatic lir_grp_e lir_group(int word, int nw);
    return lir_grp_e'(2'(word / nw));
  endfunction

  // word index inside its group
  function automatic int lir_slot(int word, int nw);
    return word % nw;
  endfunction

endpackage

// File: rtl/lir_sync.sv
module lir_sync #(
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;

endmodule

// File: rtl/lir_decode.sv
module lir_decode
  import lir_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 10,
  parameter int SLOT_W    = 2,
  parameter int BANK_W    = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output lir_grp_e          grp,
  output logic [SLOT_W-1:0] slot,
  output logic [BANK_W-1:0] bank
);

  localparam int NW        = lir_words(NUM_LINES);
  localparam int STRIDE_LG = lir_stride_lg(NUM_LINES);

  logic [STRIDE_LG-3:0]         word_off;
  logic [ADDR_W-STRIDE_LG-1:0]  bank_field;

  assign word_off   = addr[STRIDE_LG-1:2];
  assign bank_field = addr[ADDR_W-1:STRIDE_LG];

  always_comb begin
    hit  = (int'(bank_field) < NUM_CPUS) && (int'(word_off) < 4 * NW);
    grp  = lir_group(int'(word_off), NW);
    slot = SLOT_W'(lir_slot(int'(word_off), NW));
    bank = BANK_W'(bank_field);
  end

endmodule

// File: rtl/lir_bank.sv
module lir_bank #(
  parameter int NUM_LINES = 96,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] status,
  input  logic                 set_stb,
  input  logic                 clr_stb,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [31:0]          wdata,
  output logic [NUM_LINES-1:0] mask_o,
  output logic                 irq_o
);

  logic [NUM_LINES-1:0] mask_q;
  logic                 irq_q;
  logic [NUM_LINES-1:0] placed;
  logic [NUM_LINES-1:0] set_bits;
  logic [NUM_LINES-1:0] clr_bits;
  logic                 pend_any;

  // write data moved to the lines of the addressed word
  assign placed   = NUM_LINES'(wdata) << (32 * int'(slot));
  assign set_bits = set_stb ? placed : '0;
  assign clr_bits = clr_stb ? placed : '0;
  assign pend_any = |(status & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= (mask_q | set_bits) & ~clr_bits;
      irq_q  <= pend_any;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R3: every bit written as 1 to the set word is masked afterwards
  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask_q & $past(set_bits)) == $past(set_bits)));

  // R4: every bit written as 1 to the clear word is unmasked afterwards
  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((mask_q & $past(clr_bits)) == '0));

  // R7: without a set or clear strobe the mask holds
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(mask_q));

  // R5: a fully masked bank keeps its output low
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_q);

  // R5: the output can only rise when some line was high
  assert_rise_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|status));

endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lir_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_CPUS-1:0]  cpu_irq
);

  localparam int NW     = lir_words(NUM_LINES);
  localparam int SLOT_W = $clog2(NW);
  localparam int BANK_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

  if (NUM_LINES != 64 && NUM_LINES != 96 && NUM_LINES != 128 && NUM_LINES != 160) begin : g_bad_lines
    $error("NUM_LINES must be 64, 96, 128 or 160");
  end

  logic [NUM_LINES-1:0] status;
  logic                 dec_hit;
  lir_grp_e             dec_grp;
  logic [SLOT_W-1:0]    dec_slot;
  logic [BANK_W-1:0]    dec_bank;
  logic                 wr_en;
  logic                 rd_en;
  logic [NUM_LINES-1:0] masks [NUM_CPUS];
  logic [31:0]          rd_word;
  logic [31:0]          rdata_q;

  lir_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (irq_in),
    .q_out (status)
  );

  lir_decode #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPUS  (NUM_CPUS),
    .ADDR_W    (ADDR_W),
    .SLOT_W    (SLOT_W),
    .BANK_W    (BANK_W)
  ) u_decode (
    .addr (addr),
    .hit  (dec_hit),
    .grp  (dec_grp),
    .slot (dec_slot),
    .bank (dec_bank)
  );

  assign wr_en = req && we && dec_hit;
  assign rd_en = req && !we;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    logic sel;
    assign sel = wr_en && (int'(dec_bank) == c);

    lir_bank #(
      .NUM_LINES (NUM_LINES),
      .SLOT_W    (SLOT_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .status  (status),
      .set_stb (sel && (dec_grp == GRP_MSET)),
      .clr_stb (sel && (dec_grp == GRP_MCLR)),
      .slot    (dec_slot),
      .wdata   (wdata),
      .mask_o  (masks[c]),
      .irq_o   (cpu_irq[c])
    );
  end

  always_comb begin
    rd_word = '0;
    if (dec_hit) begin
      if (dec_grp == GRP_STATUS) begin
        rd_word = status[32*int'(dec_slot) +: 32];
      end else begin
        rd_word = masks[dec_bank][32*int'(dec_slot) +: 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_word;
    end
  end

  assign rdata = rdata_q;

  // R9: a read outside the implemented words returns zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !dec_hit) |=> (rdata == 32'h0));

  // R10: read data is held while no read is requested
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/test_lvl_irq_router.sv
`timescale 1ns/1ps
module test_lvl_irq_router;
  localparam int L  = 96;
  localparam int NC = 2;
  localparam int AW = 10;
  localparam int NW = L / 32;
  localparam int STRIDE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] irq_in = '0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire  [NC-1:0] cpu_irq;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  lvl_irq_router #(.NUM_LINES(L), .NUM_CPUS(NC), .ADDR_W(AW)) i_lvl_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq)
  );

  // ---------------- behavioural reference ----------------
  logic [L-1:0]  m_s1, m_st;
  logic [L-1:0]  m_mask [NC];
  logic [NC-1:0] m_irq;
  logic [31:0]   m_rd;

  function automatic logic [31:0] m_read(int a);
    int bank = a / STRIDE;
    int word = (a % STRIDE) / 4;
    if (bank >= NC || word >= 4 * NW) return 32'h0;
    if (word < NW) return m_st[(word % NW) * 32 +: 32];
    return m_mask[bank][(word % NW) * 32 +: 32];
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [L-1:0] nm [NC];
    int bank, word, grp;
    if (!rst_n) begin
      m_s1 = '0; m_st = '0; m_irq = '0; m_rd = '0;
      for (int c = 0; c < NC; c++) m_mask[c] = '1;
    end else begin
      for (int c = 0; c < NC; c++) nm[c] = m_mask[c];
      if (req && we) begin
        bank = int'(addr) / STRIDE;
        word = (int'(addr) % STRIDE) / 4;
        if (bank < NC && word < 4 * NW) begin
          grp = word / NW;
          if (grp == 2) nm[bank][(word % NW) * 32 +: 32] = nm[bank][(word % NW) * 32 +: 32] | wdata;
          if (grp == 3) nm[bank][(word % NW) * 32 +: 32] = nm[bank][(word % NW) * 32 +: 32] & ~wdata;
        end
      end
      if (req && !we) m_rd = m_read(int'(addr));
      for (int c = 0; c < NC; c++) m_irq[c] = |(m_st & ~m_mask[c]);
      m_st = m_s1;
      m_s1 = irq_in;
      for (int c = 0; c < NC; c++) m_mask[c] = nm[c];
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (cpu_irq !== m_irq) begin
        miscompares++;
        $display("FAIL R5 cpu_irq actual=%b expected=%b", cpu_irq, m_irq);
      end
      vectors++;
      if (rdata !== m_rd) begin
        miscompares++;
        $display("FAIL R8 R10 rdata actual=%h expected=%h", rdata, m_rd);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  // ---------------- directed and random stimulus ----------------
  initial begin : stim
    logic [31:0] d;
    logic [L-1:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd(c * STRIDE + 4 * (NW + w), d);
        chk("R1 mask all ones", d, 32'hFFFF_FFFF);
      end

    // R2 status words follow the inputs
    pat = 96'h0000_0040_8001_0000_C3C3_0010;
    irq_in = pat;
    repeat (4) @(negedge clk);
    for (int w = 0; w < NW; w++) begin
      rd(4 * w, d);
      chk("R2 status word bank0", d, pat[32*w +: 32]);
      rd(STRIDE + 4 * w, d);
      chk("R2 status word bank1", d, pat[32*w +: 32]);
    end
    chk("R5 all masked output low", 32'(cpu_irq), 32'h0);

    // R4 unmask line 4 on bank0 only
    wr(4 * (3 * NW), 32'h0000_0010);
    repeat (3) @(negedge clk);
    chk("R6 bank0 output high", 32'(cpu_irq[0]), 32'h1);
    chk("R6 bank1 output low", 32'(cpu_irq[1]), 32'h0);
    rd(4 * NW, d);
    chk("R4 mask after clear", d, 32'hFFFF_FFEF);
    rd(STRIDE + 4 * NW, d);
    chk("R6 bank1 mask untouched", d, 32'hFFFF_FFFF);
    wr(4 * (3 * NW), 32'h0);
    rd(4 * NW, d);
    chk("R4 zero bits keep mask", d, 32'hFFFF_FFEF);

    // R3 set with zero, then set line 4
    wr(4 * (2 * NW), 32'h0);
    rd(4 * NW, d);
    chk("R3 zero bits keep mask", d, 32'hFFFF_FFEF);
    wr(4 * (2 * NW), 32'h0000_0010);
    repeat (2) @(negedge clk);
    chk("R3 masked output low", 32'(cpu_irq[0]), 32'h0);
    rd(4 * NW, d);
    chk("R3 mask after set", d, 32'hFFFF_FFFF);

    // R7 writes to status and mask view ignored
    wr(STRIDE + 4 * NW, 32'h0);
    wr(STRIDE + 0, 32'h0);
    rd(STRIDE + 4 * NW, d);
    chk("R7 mask view write ignored", d, 32'hFFFF_FFFF);
    rd(STRIDE + 0, d);
    chk("R7 status write ignored", d, pat[31:0]);

    // R8 set and clear words read back the mask
    wr(STRIDE + 4 * (3 * NW + 2), 32'h0000_0040);
    rd(STRIDE + 4 * (2 * NW + 2), d);
    chk("R8 set word reads mask", d, 32'hFFFF_FFBF);
    rd(STRIDE + 4 * (3 * NW + 2), d);
    chk("R8 clear word reads mask", d, 32'hFFFF_FFBF);

    // R5 level follow on line 70 routed to bank1
    repeat (2) @(negedge clk);
    chk("R5 routed line high", 32'(cpu_irq), 32'h2);
    irq_in[70] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 output falls with input", 32'(cpu_irq), 32'h0);

    // R9 unmapped reads and writes
    rd(4 * NW * 4, d);
    chk("R9 beyond window", d, 32'h0);
    rd(2 * STRIDE + 0, d);
    chk("R9 missing bank", d, 32'h0);
    wr(2 * STRIDE + 4 * (3 * NW), 32'hFFFF_FFFF);
    wr(STRIDE - 4, 32'hFFFF_FFFF);
    rd(4 * NW, d);
    chk("R9 unmapped write ignored bank0", d, 32'hFFFF_FFFF);

    // random traffic compared every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) irq_in = {$urandom(), $urandom(), $urandom()};
      req   = ($urandom_range(0, 1) == 1);
      we    = ($urandom_range(0, 1) == 1);
      addr  = AW'($urandom_range(0, 255) & 32'hFC);
      wdata = $urandom();
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule